// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block sits between a bank of general-purpose pads and the peripherals of a chip and decides, under software control, which peripheral signal reaches which pad and which pad reaches which peripheral input. In the outward direction every pad owns two independent 8-bit selectors. One picks the level driven onto the pad and the other picks the pad's output enable. Each selector can name a constant or any peripheral signal. In the inward direction the map is reversed: every peripheral input owns an 8-bit selector that names the pad feeding it (pad number plus two), or one of two constants.

Software sees a flat bank of 32-bit words through a word address, a write strobe, four byte enables, write data and combinational read data. Selector fields are packed four to a word, one per byte. Writing one byte never disturbs the other three, so a driver can update a single pad with a read-modify-write. A read-only status region returns the raw pad input levels, 32 pads per word.

The default build has 16 pads, 12 peripheral output signals, 6 peripheral output-enable signals and 8 peripheral inputs. Word addresses 0-3 hold the data selectors, 4-7 the enable selectors, 8-9 the input selectors and 10 the pad status. Every region base is derived from the parameters.

Top module: `gpx_crossbar`

## Requirements
- R1: While reset is held and after it is released, every pad has pad_oe=0 and pad_out=0 and every periph_in bit is 0. Every data selector reads back 8'h00, every enable selector 8'h01 and every input selector 8'h00.
- R2: The data selector of pad p is byte p%4 (bits 8*(p%4)+7 downto 8*(p%4)) of word p/4. Code 0 drives pad_out low, code 1 drives it high, and code 2+k drives periph_out[k].
- R3: The enable selector of pad p is byte p%4 of word OE_BASE+p/4 (OE_BASE=4 by default). Code 0 sets pad_oe=1, code 1 sets pad_oe=0, and code 2+k passes periph_oe[k].
- R4: A data or enable selector code at or above 2 plus the number of matching peripheral signals drives 0 on pad_out or pad_oe.
- R5: The input selector of peripheral input s is byte s%4 of word IN_BASE+s/4 (IN_BASE=8 by default). Code 0 gives 0, code 1 gives 1, and code 2+p gives pad_in[p]. Any code at or above NUM_PADS+2 gives 0.
- R6: Reading word ST_BASE+j (ST_BASE=10 by default) returns pad_in[32j+b] in bit b, with 0 in bits beyond the last pad. Writes to this region change nothing.
- R7: A write updates only the bytes whose byte enable is 1. All other fields, in the same word or elsewhere, keep their values.
- R8: A read returns the current field values of the addressed word, or 0 for an address outside every region. Writes to such an address change no field.
- R9: The data and enable of one pad are chosen independently: each follows its own selected signal whatever the other selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (6) | Word address for reads and writes |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PADS (16) | Levels seen at the pads |
| pad_out | output | NUM_PADS (16) | Level driven onto each pad |
| pad_oe | output | NUM_PADS (16) | Drive enable per pad, 1 = output |
| periph_out | input | NUM_POUT (12) | Peripheral output data signals |
| periph_oe | input | NUM_POE (6) | Peripheral output-enable signals |
| periph_in | output | NUM_PIN (8) | Peripheral input signals |

## Verification
The bench aims at the edges of each code space. It selects the last valid peripheral and pad codes and the first code past them. A decoder with an off-by-one error would either route a nonexistent signal or drop the last real one. It writes with partial and empty byte enables and reads the neighbouring fields back, because a bank that ignored strobes would clobber the other three pads of the word. It also writes to the status region and to an unmapped address and then checks that no selector moved and that status still tracks the pads. It drives data and enable from different sources on one pad, which catches a design that ties the two selectors together or swaps the enable codes.

// File: rtl/gpx_pkg.sv
// Shared constants for the GPIO routing crossbar.
// Assumes 8-bit selector fields packed four per 32-bit word.
package gpx_pkg;
    localparam int FIELD_W   = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = FIELD_W * LANES;
    localparam int STAT_BITS = 32;

    // Reserved selector codes; signal k is code SEL_FIRST+k
    localparam logic [FIELD_W-1:0] SEL_ZERO  = 8'd0;
    localparam logic [FIELD_W-1:0] SEL_ONE   = 8'd1;
    localparam int                 SEL_FIRST = 2;

    // Output-enable codes: first drives the pad, second releases it
    localparam logic [FIELD_W-1:0] OE_DRIVE   = 8'd0;
    localparam logic [FIELD_W-1:0] OE_RELEASE = 8'd1;

    // Number of containers of size per needed for n items
    function automatic int ceil_div(input int n, input int per);
        return (n + per - 1) / per;
    endfunction
endpackage

// File: rtl/gpx_field_bank.sv
// Bank of byte-wide selector fields packed four per word.
// Does: byte-strobed writes, reset to one code, combinational word read.
// Assumes: wr_en is already qualified to this bank; word offsets are bank-local.
module gpx_field_bank
    import gpx_pkg::*;
#(
    parameter int                 NFIELDS  = 16,
    parameter int                 ADDR_W   = 6,
    parameter logic [FIELD_W-1:0] RST_CODE = 8'd0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_word,
    input  logic [LANES-1:0]            wr_be,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_word,
    output logic [WORD_W-1:0]           rd_data,
    output logic [NFIELDS*FIELD_W-1:0]  fields
);
    logic [FIELD_W-1:0] q [NFIELDS];

    for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
        localparam int WI = f / LANES;
        localparam int LI = f % LANES;
        logic hit;
        assign hit = wr_en && (wr_word == ADDR_W'(WI)) && wr_be[LI];

        // Hold one selector byte; load it only when its own lane is strobed
        always_ff @(posedge clk) begin
            if (!rst_n)   q[f] <= RST_CODE;
            else if (hit) q[f] <= wr_data[FIELD_W*LI +: FIELD_W];
        end

        assign fields[FIELD_W*f +: FIELD_W] = q[f];

        // R7: a field whose lane was not strobed keeps its value
        a_r7_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_word == ADDR_W'(WI) && wr_be[LI]) |=> $stable(fields[FIELD_W*f +: FIELD_W]))
            else $error("field %0d changed without its strobe", f);
    end

    // Assemble the addressed word; bytes without a field read as zero
    always_comb begin
        rd_data = '0;
        for (int f = 0; f < NFIELDS; f++) begin
            if (rd_word == ADDR_W'(f / LANES))
                rd_data[FIELD_W*(f % LANES) +: FIELD_W] = q[f];
        end
    end
endmodule

// File: rtl/gpx_sel_mux.sv
// One selector decoder: two reserved constant codes, then N source signals.
// Does: code 0 -> C0, code 1 -> C1, code 2+k -> src[k], anything else -> 0.
// Assumes: N + 2 fits in the field width.
module gpx_sel_mux
    import gpx_pkg::*;
#(
    parameter int N  = 12,
    parameter bit C0 = 1'b0,
    parameter bit C1 = 1'b1
) (
    input  logic [FIELD_W-1:0] sel,
    input  logic [N-1:0]       src,
    output logic               y
);
    // Compare against each source code so no out-of-range index is formed
    always_comb begin
        y = 1'b0;
        if (sel == SEL_ZERO)      y = C0;
        else if (sel == SEL_ONE)  y = C1;
        else begin
            for (int k = 0; k < N; k++) begin
                if (sel == FIELD_W'(k + SEL_FIRST)) y = src[k];
            end
        end
    end
endmodule

// File: rtl/gpx_crossbar.sv
// GPIO routing crossbar top.
// Does: decodes the word address into data, enable, input and status regions,
// routes peripheral data and enable onto pads, and routes pads to peripheral inputs.
// Assumes: ADDR_W covers all regions; NUM_PADS+2 and NUM_POUT+2 fit in 8 bits.
module gpx_crossbar
    import gpx_pkg::*;
#(
    parameter int NUM_PADS = 16,
    parameter int NUM_POUT = 12,
    parameter int NUM_POE  = 6,
    parameter int NUM_PIN  = 8,
    parameter int ADDR_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [LANES-1:0]     reg_be,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_PADS-1:0]  pad_in,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe,
    input  logic [NUM_POUT-1:0]  periph_out,
    input  logic [NUM_POE-1:0]   periph_oe,
    output logic [NUM_PIN-1:0]   periph_in
);
    localparam int PAD_WORDS = ceil_div(NUM_PADS, LANES);
    localparam int IN_WORDS  = ceil_div(NUM_PIN, LANES);
    localparam int ST_WORDS  = ceil_div(NUM_PADS, STAT_BITS);
    localparam int OE_BASE   = PAD_WORDS;
    localparam int IN_BASE   = 2 * PAD_WORDS;
    localparam int ST_BASE   = IN_BASE + IN_WORDS;
    localparam int END_ADDR  = ST_BASE + ST_WORDS;

    typedef enum logic [2:0] {RG_DATA, RG_EN, RG_IN, RG_STAT, RG_NONE} region_t;

    region_t             region;
    logic [ADDR_W-1:0]   off;
    logic [WORD_W-1:0]   rd_dout, rd_oe, rd_in, rd_stat;
    logic [NUM_PADS*FIELD_W-1:0] dout_f, oe_f;
    logic [NUM_PIN*FIELD_W-1:0]  in_f;

    // Classify the address and form its offset inside the region
    always_comb begin
        if (reg_addr < ADDR_W'(OE_BASE)) begin
            region = RG_DATA; off = reg_addr;
        end else if (reg_addr < ADDR_W'(IN_BASE)) begin
            region = RG_EN;   off = reg_addr - ADDR_W'(OE_BASE);
        end else if (reg_addr < ADDR_W'(ST_BASE)) begin
            region = RG_IN;   off = reg_addr - ADDR_W'(IN_BASE);
        end else if (reg_addr < ADDR_W'(END_ADDR)) begin
            region = RG_STAT; off = reg_addr - ADDR_W'(ST_BASE);
        end else begin
            region = RG_NONE; off = '0;
        end
    end

    gpx_field_bank #(.NFIELDS(NUM_PADS), .ADDR_W(ADDR_W), .RST_CODE(SEL_ZERO)) u_dout_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en && region == RG_DATA),
        .wr_word(off), .wr_be(reg_be), .wr_data(reg_wdata),
        .rd_word(off), .rd_data(rd_dout), .fields(dout_f));

    gpx_field_bank #(.NFIELDS(NUM_PADS), .ADDR_W(ADDR_W), .RST_CODE(OE_RELEASE)) u_oe_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en && region == RG_EN),
        .wr_word(off), .wr_be(reg_be), .wr_data(reg_wdata),
        .rd_word(off), .rd_data(rd_oe), .fields(oe_f));

    gpx_field_bank #(.NFIELDS(NUM_PIN), .ADDR_W(ADDR_W), .RST_CODE(SEL_ZERO)) u_in_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en && region == RG_IN),
        .wr_word(off), .wr_be(reg_be), .wr_data(reg_wdata),
        .rd_word(off), .rd_data(rd_in), .fields(in_f));

    // Gather raw pad levels for the addressed status word
    always_comb begin
        rd_stat = '0;
        for (int b = 0; b < NUM_PADS; b++) begin
            if (off == ADDR_W'(b / STAT_BITS))
                rd_stat[b % STAT_BITS] = pad_in[b];
        end
    end

    // Select read data by region; unmapped addresses read zero
    always_comb begin
        unique case (region)
            RG_DATA: reg_rdata = rd_dout;
            RG_EN:   reg_rdata = rd_oe;
            RG_IN:   reg_rdata = rd_in;
            RG_STAT: reg_rdata = rd_stat;
            default: reg_rdata = '0;
        endcase
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpx_sel_mux #(.N(NUM_POUT), .C0(1'b0), .C1(1'b1)) u_data (
            .sel(dout_f[FIELD_W*p +: FIELD_W]), .src(periph_out), .y(pad_out[p]));
        gpx_sel_mux #(.N(NUM_POE), .C0(1'b1), .C1(1'b0)) u_en (
            .sel(oe_f[FIELD_W*p +: FIELD_W]), .src(periph_oe), .y(pad_oe[p]));

        // R3: the drive code always enables the pad
        a_r3_drive_code: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_f[FIELD_W*p +: FIELD_W] == OE_DRIVE) |-> pad_oe[p])
            else $error("pad %0d not driven under drive code", p);
        // R4: unused data codes give a low pad
        a_r4_unused_data: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(dout_f[FIELD_W*p +: FIELD_W]) >= NUM_POUT + SEL_FIRST) |-> !pad_out[p])
            else $error("pad %0d high under unused data code", p);
        // R4: unused enable codes release the pad
        a_r4_unused_en: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(oe_f[FIELD_W*p +: FIELD_W]) >= NUM_POE + SEL_FIRST) |-> !pad_oe[p])
            else $error("pad %0d enabled under unused code", p);
    end

    for (genvar s = 0; s < NUM_PIN; s++) begin : g_pin
        gpx_sel_mux #(.N(NUM_PADS), .C0(1'b0), .C1(1'b1)) u_route (
            .sel(in_f[FIELD_W*s +: FIELD_W]), .src(pad_in), .y(periph_in[s]));

        // R5: a pad code delivers that pad's level
        a_r5_pad_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(in_f[FIELD_W*s +: FIELD_W]) >= SEL_FIRST &&
             int'(in_f[FIELD_W*s +: FIELD_W]) < NUM_PADS + SEL_FIRST)
            |-> periph_in[s] == pad_in[int'(in_f[FIELD_W*s +: FIELD_W]) - SEL_FIRST])
            else $error("input %0d does not follow its pad", s);
    end

    // R1: right after reset no pad drives and all peripheral inputs are low
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && periph_in == '0))
        else $error("outputs not quiet after reset");
    // R6: the first status word mirrors the low pads
    a_r6_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ST_BASE)) |-> reg_rdata[0] == pad_in[0])
        else $error("status bit 0 does not mirror pad 0");
    // R8: unmapped addresses read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(END_ADDR)) |-> reg_rdata == '0)
        else $error("unmapped read not zero");
endmodule

// File: tb/sim_gpx_crossbar.sv
// Directed bench for gpx_crossbar: one task per scenario, each checking its results.
module sim_gpx_crossbar;
    localparam int NP = 16, NPO = 12, NPE = 6, NPI = 8, AW = 6;
    localparam int OE_B = 4, IN_B = 8, ST_B = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic            reg_wr_en = 1'b0;
    logic [3:0]      reg_be = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe;
    logic [NPO-1:0]  periph_out = '0;
    logic [NPE-1:0]  periph_oe = '0;
    logic [NPI-1:0]  periph_in;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpx_crossbar #(.NUM_PADS(NP), .NUM_POUT(NPO), .NUM_POE(NPE), .NUM_PIN(NPI), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in));

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        settle();
        check("R1", "pad_oe after reset", 32'(pad_oe), 32'h0);
        check("R1", "pad_out after reset", 32'(pad_out), 32'h0);
        check("R1", "periph_in after reset", 32'(periph_in), 32'h0);
        rd(0, d);        check("R1", "data selectors", d, 32'h0);
        rd(OE_B + 3, d); check("R1", "enable selectors", d, 32'h01010101);
        rd(IN_B + 1, d); check("R1", "input selectors", d, 32'h0);
    endtask

    task automatic t_data();
        logic [31:0] d;
        // pad0 code1 high, pad1 code0 low, pad2 -> periph_out[3], pad3 -> periph_out[11] (last)
        wr(0, {8'd13, 8'd5, 8'd0, 8'd1}, 4'hF);
        periph_out = 12'h808; settle();
        check("R2", "pad_out[3:0] pattern A", 32'(pad_out[3:0]), 32'hD);
        @(negedge clk); periph_out = 12'h7F7; settle();
        check("R2", "pad_out[3:0] pattern B", 32'(pad_out[3:0]), 32'h1);
        rd(0, d); check("R8", "data word readback", d, 32'h0D050001);
    endtask

    task automatic t_enable();
        // pad0 drive, pad1 release, pad2 -> periph_oe[0], pad3 -> periph_oe[5] (last)
        wr(OE_B, {8'd7, 8'd2, 8'd1, 8'd0}, 4'hF);
        @(negedge clk); periph_oe = 6'b100000; settle();
        check("R3", "pad_oe[3:0] pattern A", 32'(pad_oe[3:0]), 32'h9);
        @(negedge clk); periph_oe = 6'b011111; settle();
        check("R3", "pad_oe[3:0] pattern B", 32'(pad_oe[3:0]), 32'h5);
    endtask

    task automatic t_unused();
        // pad4 data code 14 (first unused), pad5 code 255; pad4 enable code 8 (first unused)
        wr(1, {8'd0, 8'd0, 8'd255, 8'd14}, 4'h3);
        wr(OE_B + 1, {8'd1, 8'd1, 8'd1, 8'd8}, 4'h1);
        @(negedge clk); periph_out = '1; periph_oe = '1; settle();
        check("R4", "unused data codes low", 32'(pad_out[5:4]), 32'h0);
        check("R4", "unused enable code low", 32'(pad_oe[4]), 32'h0);
    endtask

    task automatic t_independent();
        // pad6 data -> periph_out[2], enable -> periph_oe[4]
        wr(1, 32'h00040000, 4'h4);
        wr(OE_B + 1, 32'h00060000, 4'h4);
        @(negedge clk); periph_out = 12'h004; periph_oe = 6'h00; settle();
        check("R9", "data high, enable low", {30'd0, pad_out[6], pad_oe[6]}, 32'h2);
        @(negedge clk); periph_out = 12'h000; periph_oe = 6'h10; settle();
        check("R9", "data low, enable high", {30'd0, pad_out[6], pad_oe[6]}, 32'h1);
    endtask

    task automatic t_input();
        // sig0 const0, sig1 const1, sig2 <- pad7, sig3 <- pad15 (last); sig4 code 18 (first unused), sig5 <- pad0
        wr(IN_B, {8'd17, 8'd9, 8'd1, 8'd0}, 4'hF);
        wr(IN_B + 1, {8'd0, 8'd0, 8'd2, 8'd18}, 4'hF);
        @(negedge clk); pad_in = 16'h8081; settle();
        check("R5", "periph_in pattern A", 32'(periph_in[5:0]), 32'h2E);
        @(negedge clk); pad_in = 16'h7F7E; settle();
        check("R5", "periph_in pattern B", 32'(periph_in[5:0]), 32'h02);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'hA5C3;
        rd(ST_B, d); check("R6", "status word", d, 32'h0000A5C3);
        wr(ST_B, 32'hFFFFFFFF, 4'hF);
        rd(ST_B, d); check("R6", "status after write", d, 32'h0000A5C3);
        rd(0, d);    check("R6", "data word unaffected by status write", d, 32'h0D050001);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        wr(2, 32'h04030201, 4'hF);
        wr(2, 32'hFFAAFFFF, 4'h4);
        rd(2, d); check("R7", "single lane write", d, 32'h04AA0201);
        wr(2, 32'hEEEEEEEE, 4'h0);
        rd(2, d); check("R7", "empty strobe write", d, 32'h04AA0201);
        rd(3, d); check("R7", "neighbour word untouched", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(6'd20, 32'h12345678, 4'hF);
        rd(6'd20, d);    check("R8", "unmapped read", d, 32'h0);
        rd(IN_B, d);     check("R8", "input word after unmapped write", d, 32'h11090100);
        rd(OE_B + 1, d); check("R8", "enable word after unmapped write", d, 32'h01060108);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();          // R1 while held
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();          // R1 after release
        t_data();
        t_enable();
        t_unused();
        t_independent();
        t_input();
        t_status();
        t_bytes();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule